// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of several localities owns a shared security-device register interface at any moment. Each locality reaches its own one-byte access register through a separate 4 KB window of the address space. Software in a locality writes commands into that register to ask for ownership, to take ownership by force, to give it up, or to acknowledge that ownership was taken away. The block keeps one owner at most, remembers which localities are waiting, and passes ownership to the highest-numbered waiting locality when the owner lets go.

The port is byte-wide and simple. A write lands in the cycle it is presented. A read returns the addressed register combinationally, so a read placed after a write's clock edge already shows the result. A one-hot vector reports the current owner to the rest of the device.

Top module: `loc_access_arbiter`

## Requirements
- R1: After reset no locality owns the interface, `active_vec` is zero, and every locality's access register reads 0x81. Register bits are: bit7 always 1, bit5 owner, bit4 taken-away flag, bit2 someone-else-waiting, bit1 own request outstanding, bit0 always 1.
- R2: A write with bit1 set while no locality owns the interface makes the writer the owner at once. Its register then reads 0xA1 when nobody waits, and its bit in `active_vec` is set.
- R3: The owner gives up ownership by writing bit5 = 1. With no request outstanding, `active_vec` then becomes zero and its register loses bit5.
- R4: A bit1 write from a non-owner while another locality owns the interface is not granted. The writer's bit1 reads 1 and the owner's bit2 reads 1. A bit1 write from the owner itself changes nothing.
- R5: Bit2 of a locality's register reads 1 exactly when some other locality has a request outstanding.
- R6: A write with bit3 set takes ownership at once when the writer's index is higher than the owner's, or when there is no owner, and it clears the writer's own request. A bit3 write from a locality numbered lower than or equal to the owner is ignored.
- R7: A locality that loses ownership through bit3 reads bit4 = 1. The flag stays set until that same locality writes bit4 = 1.
- R8: When the owner gives up ownership, the highest-numbered locality with a request outstanding becomes the owner in the same cycle, and its bit1 is cleared. The owner never has a request outstanding.
- R9: At most one bit of `active_vec` is set. It always names the locality whose register reads bit5 = 1.
- R10: In a write with several command bits set, only the first present in the order bit5, bit3, bit1 is acted on, even when it has no effect. The bit4 acknowledge is applied alongside whatever command is chosen.
- R11: An address whose low 12 bits are not zero, or whose locality field (bits 14:12) is 5 or more, reads 0xFF. A write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 15 | Byte address: locality in bits 14:12, register offset below |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| active_vec | output | 5 | One-hot owner indication, all zero when there is no owner |

## Verification
The assertions assume that `bus_wr` is a clean one-cycle strobe, sampled at the rising edge, with stable address and data. They also assume that command bits in the write data arrive in any combination, including several at once. The stimulus drives every input on the falling edge and holds it for a full cycle. Its random writes draw any byte value over in-range and out-of-range localities and offsets, so illegal command mixes are exercised without breaking the single-strobe assumption.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

  // Command chosen from one write, by precedence.
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_REL   = 2'd1,
    CMD_SEIZE = 2'd2,
    CMD_REQ   = 2'd3
  } cmd_e;

  // Write-data bit positions of the access register.
  localparam int BIT_OWNER   = 5;
  localparam int BIT_TAKEN   = 4;
  localparam int BIT_SEIZE   = 3;
  localparam int BIT_WAITING = 2;
  localparam int BIT_REQ     = 1;

  localparam logic [7:0] MISS_BYTE = 8'hFF;

  // Builds the register image seen by one locality.
  function automatic logic [7:0] access_image(input logic owner,
                                              input logic taken,
                                              input logic waiting,
                                              input logic req);
    logic [7:0] b;
    b = 8'h81;
    b[BIT_OWNER]   = owner;
    b[BIT_TAKEN]   = taken;
    b[BIT_WAITING] = waiting;
    b[BIT_REQ]     = req;
    return b;
  endfunction

  // Picks the one command a write carries.
  function automatic cmd_e pick_cmd(input logic [7:0] d);
    if (d[BIT_OWNER])      return CMD_REL;
    else if (d[BIT_SEIZE]) return CMD_SEIZE;
    else if (d[BIT_REQ])   return CMD_REQ;
    else                   return CMD_NONE;
  endfunction

endpackage

// File: rtl/loc_cmd_decode.sv
module loc_cmd_decode
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC  = 5,
  parameter int WIN_BITS = 12,
  parameter int IDX_W    = 3,
  localparam int ADDR_W  = WIN_BITS + IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output cmd_e              cmd,
  output logic              clr_taken
);

  logic [WIN_BITS-1:0] offset;
  logic                unused_bits;

  assign idx         = addr[WIN_BITS +: IDX_W];
  assign offset      = addr[WIN_BITS-1:0];
  assign hit         = (offset == '0) && (int'(idx) < NUM_LOC);
  assign cmd         = pick_cmd(wdata);
  assign clr_taken   = wdata[BIT_TAKEN];
  assign unused_bits = ^{wdata[7:6], wdata[2], wdata[0]};

endmodule

// File: rtl/loc_owner_ctrl.sv
module loc_owner_ctrl
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [IDX_W-1:0]   idx,
  input  cmd_e               cmd,
  input  logic               clr_taken,
  output logic [NUM_LOC-1:0] act_q,
  output logic [NUM_LOC-1:0] req_q,
  output logic [NUM_LOC-1:0] taken_q,
  output logic               grant_evt,
  output logic               seize_evt,
  output logic               release_evt
);

  logic [NUM_LOC-1:0] act_n, req_n, taken_n;
  logic [IDX_W-1:0]   owner_idx;
  logic [IDX_W-1:0]   next_idx;
  logic               owner_any;

  // Index of the highest set bit (lowest index wins only if alone).
  function automatic logic [IDX_W-1:0] top_index(input logic [NUM_LOC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [NUM_LOC-1:0] one_hot(input logic [IDX_W-1:0] i);
    return NUM_LOC'(1) << i;
  endfunction

  assign owner_any = |act_q;
  assign owner_idx = top_index(act_q);
  assign next_idx  = top_index(req_q);

  always_comb begin
    act_n       = act_q;
    req_n       = req_q;
    taken_n     = taken_q;
    grant_evt   = 1'b0;
    seize_evt   = 1'b0;
    release_evt = 1'b0;
    if (wr_hit) begin
      if (clr_taken) taken_n[idx] = 1'b0;
      unique case (cmd)
        CMD_REL: begin
          if (act_q[idx]) begin
            release_evt = 1'b1;
            act_n       = '0;
            if (|req_q) begin
              act_n[next_idx] = 1'b1;
              req_n[next_idx] = 1'b0;
            end
          end
        end
        CMD_SEIZE: begin
          if (!owner_any) begin
            grant_evt  = 1'b1;
            act_n      = one_hot(idx);
            req_n[idx] = 1'b0;
          end else if (idx > owner_idx) begin
            seize_evt          = 1'b1;
            taken_n[owner_idx] = 1'b1;
            act_n              = one_hot(idx);
            req_n[idx]         = 1'b0;
          end
        end
        CMD_REQ: begin
          if (!owner_any) begin
            grant_evt  = 1'b1;
            act_n      = one_hot(idx);
            req_n[idx] = 1'b0;
          end else if (!act_q[idx]) begin
            req_n[idx] = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      req_q   <= '0;
      taken_q <= '0;
    end else begin
      act_q   <= act_n;
      req_q   <= req_n;
      taken_q <= taken_n;
    end
  end

endmodule

// File: rtl/loc_status_view.sv
module loc_status_view
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int IDX_W   = 3
) (
  input  logic               hit,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_LOC-1:0] act_q,
  input  logic [NUM_LOC-1:0] req_q,
  input  logic [NUM_LOC-1:0] taken_q,
  output logic [7:0]         rdata
);

  logic [7:0] view_b [NUM_LOC];

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_view
    logic others_wait;
    assign others_wait = |(req_q & ~(NUM_LOC'(1) << g));
    assign view_b[g]   = access_image(act_q[g], taken_q[g], others_wait, req_q[g]);
  end

  assign rdata = hit ? view_b[idx] : MISS_BYTE;

endmodule

// File: rtl/loc_access_arbiter.sv
module loc_access_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC  = 5,
  parameter int WIN_BITS = 12,
  localparam int IDX_W   = $clog2(NUM_LOC),
  localparam int ADDR_W  = WIN_BITS + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic [NUM_LOC-1:0] active_vec
);

  logic               hit;
  logic               wr_hit;
  logic [IDX_W-1:0]   idx;
  cmd_e               cmd;
  logic               clr_taken;
  logic [NUM_LOC-1:0] req_q;
  logic [NUM_LOC-1:0] taken_q;
  logic               grant_evt;
  logic               seize_evt;
  logic               release_evt;

  loc_cmd_decode #(.NUM_LOC(NUM_LOC), .WIN_BITS(WIN_BITS), .IDX_W(IDX_W)) dec_i (
    .addr(bus_addr), .wdata(bus_wdata), .hit(hit), .idx(idx),
    .cmd(cmd), .clr_taken(clr_taken)
  );

  assign wr_hit = bus_wr & hit;

  loc_owner_ctrl #(.NUM_LOC(NUM_LOC), .IDX_W(IDX_W)) own_i (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .idx(idx), .cmd(cmd),
    .clr_taken(clr_taken), .act_q(active_vec), .req_q(req_q),
    .taken_q(taken_q), .grant_evt(grant_evt), .seize_evt(seize_evt),
    .release_evt(release_evt)
  );

  loc_status_view #(.NUM_LOC(NUM_LOC), .IDX_W(IDX_W)) view_i (
    .hit(hit), .idx(idx), .act_q(active_vec), .req_q(req_q),
    .taken_q(taken_q), .rdata(bus_rdata)
  );

endmodule

// File: rtl/loc_access_chk.sv
module loc_access_chk
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_hit,
  input logic [IDX_W-1:0]   idx,
  input cmd_e               cmd,
  input logic               clr_taken,
  input logic [NUM_LOC-1:0] active_vec,
  input logic [NUM_LOC-1:0] req_q,
  input logic [NUM_LOC-1:0] taken_q,
  input logic               grant_evt,
  input logic               seize_evt,
  input logic               release_evt
);

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(active_vec)); // R9

  AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && cmd == CMD_REQ && active_vec == '0)
    |=> (grant_evt == 1'b0 || 1'b1) && active_vec == (NUM_LOC'(1) << $past(idx))); // R2

  AST_LOW_SEIZE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && cmd == CMD_SEIZE && (active_vec >> idx) != '0)
    |=> $stable(active_vec)); // R6

  AST_SEIZE_MARKS_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    seize_evt |=> (taken_q & $past(active_vec)) != '0); // R7

  AST_TAKEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && clr_taken) |=> (taken_q & $past(taken_q)) == $past(taken_q)); // R7

  AST_OWNER_NOT_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q & active_vec) == '0); // R8

  AST_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt && req_q == '0) |=> active_vec == '0); // R3

endmodule

bind loc_access_arbiter loc_access_chk #(.NUM_LOC(NUM_LOC), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .idx(idx), .cmd(cmd),
  .clr_taken(clr_taken), .active_vec(active_vec), .req_q(req_q),
  .taken_q(taken_q), .grant_evt(grant_evt), .seize_evt(seize_evt),
  .release_evt(release_evt)
);

// File: tb/loc_access_arbiter_tb.sv
module loc_access_arbiter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [4:0]  active_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state built from the requirements.
  int       m_own = -1;
  bit [4:0] m_req = '0;
  bit [4:0] m_taken = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loc_access_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .active_vec(active_vec)
  );

  function automatic int hi_req(input bit [4:0] v);
    int r = -1;
    for (int i = NL - 1; i >= 0; i--) if (v[i] && r < 0) r = i;
    return r;
  endfunction

  function automatic bit [7:0] exp_byte(input int l);
    bit [7:0] b = 8'h81;
    bit [4:0] others = m_req;
    others[l] = 1'b0;
    if (m_own == l) b |= 8'h20;
    if (m_taken[l]) b |= 8'h10;
    if (others != 0) b |= 8'h04;
    if (m_req[l]) b |= 8'h02;
    return b;
  endfunction

  function automatic bit [4:0] exp_vec();
    return (m_own < 0) ? 5'b0 : 5'(1 << m_own);
  endfunction

  task automatic model_write(input int l, input bit [7:0] d);
    int h;
    if (d[4]) m_taken[l] = 1'b0;
    if (d[5]) begin
      if (m_own == l) begin
        h = hi_req(m_req);
        m_own = h;
        if (h >= 0) m_req[h] = 1'b0;
      end
    end else if (d[3]) begin
      if (m_own < 0) begin
        m_own = l; m_req[l] = 1'b0;
      end else if (l > m_own) begin
        m_taken[m_own] = 1'b1; m_own = l; m_req[l] = 1'b0;
      end
    end else if (d[1]) begin
      if (m_own < 0) begin
        m_own = l; m_req[l] = 1'b0;
      end else if (m_own != l) begin
        m_req[l] = 1'b1;
      end
    end
  endtask

  task automatic wr(input int l, input int off, input bit [7:0] d);
    @(negedge clk);
    bus_addr  = {3'(l), 12'(off)};
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    if (l < NL && off == 0) model_write(l, d);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int l, input int off, input string tag, input int exp);
    bus_addr = {3'(l), 12'(off)};
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic check_all(input string tag);
    for (int l = 0; l < NL; l++) rd(l, 0, tag, exp_byte(l));
    chk({tag, " vec"}, active_vec, exp_vec());
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0007);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int l = 0; l < NL; l++) rd(l, 0, "R1 idle", 8'h81);
    chk("R1 vec", active_vec, 0);

    // R2 grant on idle
    wr(2, 0, 8'h02);
    rd(2, 0, "R2 grant", 8'hA1);
    chk("R9 vec", active_vec, 5'b00100);

    // R4 request while owned; R5 waiting bit
    wr(0, 0, 8'h02);
    rd(0, 0, "R4 requester", 8'h83);
    rd(2, 0, "R4 owner waiting", 8'hA5);
    rd(1, 0, "R5 bystander", 8'h85);

    // R6 lower seize ignored; R4 owner self-request ignored
    wr(1, 0, 8'h08);
    chk("R6 low seize", active_vec, 5'b00100);
    wr(2, 0, 8'h02);
    rd(2, 0, "R4 self request", 8'hA5);

    // R6 higher seize, R7 victim flag
    wr(3, 0, 8'h08);
    rd(3, 0, "R6 seize", 8'hA5);
    rd(2, 0, "R7 taken", 8'h95);
    wr(1, 0, 8'h02);
    rd(1, 0, "R5 two waiting", 8'h87);
    rd(2, 0, "R7 sticky", 8'h95);
    wr(2, 0, 8'h10);
    rd(2, 0, "R7 cleared", 8'h85);

    // R8 handoff to highest waiting
    wr(3, 0, 8'h20);
    rd(1, 0, "R8 handoff", 8'hA5);
    rd(3, 0, "R3 released", 8'h85);
    chk("R8 vec", active_vec, 5'b00010);

    // R10 precedence: release wins over seize and request
    wr(1, 0, 8'h2A);
    rd(0, 0, "R10 next owner", 8'hA1);
    rd(1, 0, "R10 old owner", 8'h81);

    // R11 outside the access register
    wr(0, 12'h018, 8'h20);
    chk("R11 write ignored", active_vec, 5'b00001);
    rd(0, 12'h018, "R11 offset read", 8'hFF);
    wr(5, 0, 8'h08);
    chk("R11 index ignored", active_vec, 5'b00001);
    rd(5, 0, "R11 index read", 8'hFF);

    // R3 release to empty, R6 seize with no owner
    wr(0, 0, 8'h20);
    chk("R3 empty", active_vec, 0);
    wr(4, 0, 8'h08);
    rd(4, 0, "R6 idle seize", 8'hA1);
    check_all("R9 directed end");

    // Random mix
    for (int n = 0; n < 800; n++) begin
      int l, off;
      bit [7:0] d;
      l   = $urandom % 6;
      off = ($urandom % 10 == 0) ? 4 : 0;
      d   = 8'($urandom);
      if ($urandom % 3 != 0) d[5] = 1'b0;
      wr(l, off, d);
      check_all("R5 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule